// File: doc/BRIEF.md
# Per-Input Edge/Level Interrupt Request Capture

This block sits in front of a priority interrupt core and turns eight raw interrupt lines into clean request bits. Each line has its own sensitivity bit in a small control register: a line set for edge sensitivity raises a request only on a low-to-high transition. A line set for level sensitivity requests for as long as it is held high. No single global mode bit exists, and every line starts in edge mode after reset. A build parameter can pin chosen lines to edge mode permanently.

The block also follows the two-pulse acknowledge handshake. When the first acknowledge pulse falls, it checks whether the level named by the core is still being requested. If so, it reports a grant for that level, clears the stored edge, and masks that level until its end-of-interrupt clear arrives. If the line was withdrawn too early, it reports a spurious acknowledge that resolves to the default level 7 and masks nothing. The second pulse of each handshake is passed over.

Top module: `irq_req_capture`

## Requirements
- R1: After reset every request bit, `grant` and `spurious` are 0, and all lines are in edge mode.
- R2: A write on `mode_we` loads `mode_wdata`. A bit value of 0 selects edge mode for that line and 1 selects level mode. Lines set in parameter `EDGE_ONLY` always stay in edge mode.
- R3: In edge mode a low-to-high transition on a line is stored and raises its request while the line stays high. A line that stays high after its grant raises no new request. The line must go low and rise again first.
- R4: In level mode the request bit follows the synchronised line level, with no edge detection.
- R5: In level mode a line that is still high when its end-of-interrupt clear (`eoi` bit i) arrives raises its request again.
- R6: From a grant of level i until `eoi` bit i, `req` bit i is held at 0.
- R7: On the falling edge of the first acknowledge pulse, if the level on `ack_lvl` is still requested, `grant` pulses for one cycle with `grant_lvl` equal to that level, and a stored edge for that level is cleared.
- R8: If the acknowledged level is no longer requested at that falling edge, `spurious` pulses for one cycle with `grant_lvl` = 7 and `grant` = 0. No level is masked and no stored edge is cleared.
- R9: The falling edge of the second acknowledge pulse of a handshake produces neither `grant` nor `spurious`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw interrupt lines, asynchronous |
| mode_we | input | 1 | Sensitivity register write strobe |
| mode_wdata | input | 8 | Sensitivity bits, 1 = level, 0 = edge |
| ack | input | 1 | Acknowledge pulse, high while active |
| ack_lvl | input | 3 | Level the core is acknowledging |
| eoi | input | 8 | Per-level end-of-interrupt clear strobe |
| req | output | 8 | Request bits to the priority core |
| grant | output | 1 | One-cycle pulse: genuine acknowledge |
| spurious | output | 1 | One-cycle pulse: request withdrawn early |
| grant_lvl | output | 3 | Resolved level for grant or spurious |

## Verification
The bench targets a line that drops in the middle of the first acknowledge pulse. A design that latched the decision when the pulse rose would grant the withdrawn level instead of reporting level 7. It also holds an edge-mode line high across its end-of-interrupt: a design that did not clear the stored edge on grant would raise a second request there. A level-mode line held high across its end-of-interrupt must come back, which catches a design that treats every line as edge. The forced-edge line and the ignored second pulse are also checked, since a design that acted on them would emit extra grants.

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8,
  parameter int LW = $clog2(N),
  parameter logic [N-1:0] EDGE_ONLY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          mode_we,
  input  logic [N-1:0]  mode_wdata,
  input  logic          ack,
  input  logic [LW-1:0] ack_lvl,
  input  logic [N-1:0]  eoi,
  output logic [N-1:0]  req,
  output logic          grant,
  output logic          spurious,
  output logic [LW-1:0] grant_lvl
);
  localparam logic [LW-1:0] DEF_LVL = LW'(N - 1);

  logic [N-1:0] s1, s2, s3, mode_q, latch, busy;
  logic ack_q, second;

  wire [N-1:0] rise  = s2 & ~s3;
  wire [N-1:0] live  = (mode_q & s2) | (~mode_q & latch & s2);
  wire         fall  = ack_q & ~ack;
  wire         first = fall & ~second;
  wire         hit   = live[ack_lvl];
  wire [N-1:0] take  = (first && hit) ? (N'(1) << ack_lvl) : '0;

  assign req = live & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      mode_q <= '0; latch <= '0; busy <= '0;
      ack_q <= 1'b0; second <= 1'b0;
      grant <= 1'b0; spurious <= 1'b0; grant_lvl <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      s3 <= s2;
      ack_q <= ack;
      if (mode_we) mode_q <= mode_wdata & ~EDGE_ONLY;
      if (fall) second <= ~second;
      latch <= (latch | rise) & ~take;
      busy  <= (busy & ~eoi) | take;
      grant <= first & hit;
      spurious <= first & ~hit;
      if (first) grant_lvl <= hit ? ack_lvl : DEF_LVL;
    end
  end
endmodule

module irq_req_capture_chk #(
  parameter int N = 8,
  parameter int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic [N-1:0]  req,
  input logic          grant,
  input logic          spurious,
  input logic [LW-1:0] grant_lvl
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (req == '0 && !grant && !spurious));
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && spurious));
  p_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || spurious) |-> !$past(ack));
  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !req[grant_lvl]);
  p_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> grant_lvl == LW'(N - 1));
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || spurious) |=> !(grant || spurious));
endmodule

bind irq_req_capture irq_req_capture_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .req(req),
  .grant(grant), .spurious(spurious), .grant_lvl(grant_lvl)
);

// File: tb/test_irq_req_capture.sv
module test_irq_req_capture;
  localparam int CLK = 10;
  localparam logic [7:0] FORCED = 8'h04;

  logic clk = 0, rst_n = 0;
  logic [7:0] irq_in = 0, mode_wdata = 0, eoi = 0, req;
  logic mode_we = 0, ack = 0, grant, spurious;
  logic [2:0] ack_lvl = 0, grant_lvl;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] m_mode = 0, m_latch = 0, m_busy = 0, m_line = 0;

  always #(CLK/2) clk = ~clk;

  irq_req_capture #(.EDGE_ONLY(FORCED)) i_irq_req_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .ack(ack), .ack_lvl(ack_lvl), .eoi(eoi),
    .req(req), .grant(grant), .spurious(spurious), .grant_lvl(grant_lvl));

  function automatic logic [7:0] live_m();
    return (m_mode & m_line) | (~m_mode & m_latch & m_line);
  endfunction
  function automatic logic [7:0] exp_req();
    return live_m() & ~m_busy;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_req(input string tag);
    check(req == exp_req(), tag, req, exp_req());
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    m_latch |= v & ~m_line;
    m_line = v;
    irq_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk);
    mode_we = 1; mode_wdata = v;
    @(negedge clk);
    mode_we = 0;
    m_mode = v & ~FORCED;
  endtask

  task automatic do_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi = v;
    @(negedge clk);
    eoi = 0;
    m_busy &= ~v;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [2:0] lvl, input bit drop, input logic [7:0] nv);
    logic hit;
    @(negedge clk);
    ack = 1; ack_lvl = lvl;
    @(negedge clk);
    if (drop) set_irq(nv);
    @(negedge clk);
    ack = 0;
    hit = live_m()[lvl];
    @(negedge clk);
    if (hit) begin
      check(grant && !spurious && grant_lvl == lvl, "R7 grant", {grant, spurious, 1'b0, grant_lvl}, {2'b10, 1'b0, lvl});
      m_latch[lvl] = 1'b0;
      m_busy[lvl] = 1'b1;
    end else begin
      check(spurious && !grant && grant_lvl == 3'd7, "R8 spurious", {grant, spurious, 1'b0, grant_lvl}, 6'b010111);
    end
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
    @(negedge clk);
    check(!grant && !spurious, "R9 second pulse", {grant, spurious}, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req == 0 && !grant && !spurious, "R1 reset", {req, grant, spurious}, 0);

    // R1: edge mode by default - held-high line requests once
    set_irq(8'h02);
    check_req("R1 R3 edge rise");
    do_ack(3'd1, 0, 0);
    check_req("R6 masked after grant");
    do_eoi(8'h02);
    check(req[1] == 1'b0, "R3 held high no re-request", req[1], 0);
    set_irq(8'h00);
    set_irq(8'h02);
    check(req[1] == 1'b1, "R3 new rise", req[1], 1);
    do_ack(3'd1, 0, 0);
    do_eoi(8'h02);

    // R4 R5 level mode
    wr_mode(8'h08);
    set_irq(8'h08);
    check(req[3] == 1'b1, "R4 level request", req[3], 1);
    do_ack(3'd3, 0, 0);
    check(req[3] == 1'b0, "R6 level masked", req[3], 0);
    do_eoi(8'h08);
    check(req[3] == 1'b1, "R5 level re-request after eoi", req[3], 1);
    set_irq(8'h00);
    check(req[3] == 1'b0, "R4 level follows line", req[3], 0);

    // R8 early drop
    set_irq(8'h20);
    do_ack(3'd5, 1, 8'h00);
    check_req("R8 nothing masked");

    // R2 forced edge line
    wr_mode(8'hFF);
    set_irq(8'h04);
    do_ack(3'd2, 0, 0);
    do_eoi(8'h04);
    check(req[2] == 1'b0, "R2 forced edge", req[2], 0);
    set_irq(8'h00);
    wr_mode(8'h00);

    for (int i = 0; i < 300; i++) begin
      case ($urandom % 4)
        0: set_irq(8'($urandom));
        1: wr_mode(8'($urandom));
        2: do_ack(3'($urandom), ($urandom % 3) == 0, 8'($urandom));
        default: do_eoi(8'($urandom));
      endcase
      check_req("R2 R3 R4 R5 R6 random");
    end
    finish_run();
  end
endmodule